// File: doc/BRIEF.md
# DRAM Open-Page Hit Controller

This block sits in front of a DRAM array and chooses, request by request, how much of the row/column access sequence must be run. A row that stays open (RAS held high) after an access can serve a later request to the same row with nothing more than a column phase. A request to any other row must first close the open row, wait out the precharge interval, and then open the new row before its column phase.

Keeping a row open is allowed separately for instruction traffic and for data traffic, through two enable inputs that software may change between requests. When keeping rows open is not allowed for the type of the request just served, the row is closed as soon as that access ends, and precharge runs before the next request is taken. The block accepts a request only while idle. The requester holds the request until it sees a one-cycle ready pulse.

Top module: `pghit_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, RAS, CAS, column select and ready are all low, and no row is held open.
- R2: A request accepted with no open row spends one compare cycle with RAS low, then one row cycle (RAS high, CAS low, column select 0), then one column cycle.
- R3: A request whose row matches the open row, when its type has open-page operation enabled, spends one compare cycle with RAS high and then goes directly to the column cycle, with RAS never falling.
- R4: A request whose row differs from an open row drives RAS low for exactly PRE_CYC cycles after the compare cycle, then runs a row cycle and a column cycle.
- R5: A matching row counts as a hit only if the enable for the request's own type is set (instruction enable for instruction requests, data enable for data requests). Otherwise the request takes the miss path of R4.
- R6: If the enable for the served request's type is clear when its column cycle ends, RAS drops, stays low for PRE_CYC cycles, and the row is then treated as not open.
- R7: Ready is high for exactly one cycle per request, in the column cycle, together with CAS high and column select 1.
- R8: Each time RAS rises, it has been low for at least PRE_CYC consecutive cycles.
- R9: CAS is never high while RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_is_instr | input | 1 | 1 = instruction request, 0 = data request |
| req_addr | input | ADDR_W | Request address; row = upper ADDR_W-COL_W bits |
| page_en_instr | input | 1 | Allow keeping rows open for instruction requests |
| page_en_data | input | 1 | Allow keeping rows open for data requests |
| dram_ras | output | 1 | Row strobe, high = row selected |
| dram_cas | output | 1 | Column strobe, high = column access |
| dram_col_sel | output | 1 | Address mux select: 0 = row, 1 = column |
| req_ready | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a row left open by one request type being found by a request of the other type whose enable differs. That case also covers enables that flip between two requests to the same row. The bench first opens a row with the data enable set. It then issues an instruction request to that row with the instruction enable clear, and later clears the data enable before a data request to a row that is still open. After these directed sequences, a long pseudo-random run draws from only four rows and toggles both enables, so hits, cross-type misses and closing precharges appear many times each.

// File: rtl/pghit_pkg.sv
package pghit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PRE,
        ST_ROW,
        ST_COL
    } pg_state_e;

endpackage

// File: rtl/pghit_row_track.sv
module pghit_row_track #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             clear,
    input  logic [ROW_W-1:0] row_in,
    output logic             row_valid,
    output logic             row_match
);

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear) begin
            trk_d.valid = 1'b0;
        end else if (capture) begin
            trk_d.valid = 1'b1;
            trk_d.row   = row_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign row_valid = trk_q.valid;
    assign row_match = trk_q.valid && (trk_q.row == row_in);

endmodule

// File: rtl/pghit_pre_timer.sv
module pghit_pre_timer #(
    parameter int PRE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CNT_W = (PRE_CYC < 2) ? 1 : $clog2(PRE_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = CNT_W'(PRE_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pghit_ctrl.sv
module pghit_ctrl
    import pghit_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int COL_W   = 10,
    parameter int PRE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_instr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              page_en_instr,
    input  logic              page_en_data,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_col_sel,
    output logic              req_ready
);

    localparam int ROW_W = ADDR_W - COL_W;

    typedef struct packed {
        pg_state_e        st;
        logic [ROW_W-1:0] row;
        logic             instr;
        logic             closing;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic trk_capture, trk_clear, trk_valid, trk_match;
    logic tmr_load, tmr_done;
    logic page_on;
    logic unused_col_bits;

    assign unused_col_bits = ^req_addr[COL_W-1:0];

    pghit_row_track #(.ROW_W(ROW_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (trk_capture),
        .clear     (trk_clear),
        .row_in    (ctl_q.row),
        .row_valid (trk_valid),
        .row_match (trk_match)
    );

    pghit_pre_timer #(.PRE_CYC(PRE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d       = ctl_q;
        trk_capture = 1'b0;
        trk_clear   = 1'b0;
        tmr_load    = 1'b0;
        page_on     = ctl_q.instr ? page_en_instr : page_en_data;

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_CHECK;
                    ctl_d.row   = req_addr[ADDR_W-1:COL_W];
                    ctl_d.instr = req_is_instr;
                end
            end
            ST_CHECK: begin
                if (trk_match && page_on) begin
                    ctl_d.st = ST_COL;
                end else if (trk_valid) begin
                    ctl_d.st      = ST_PRE;
                    ctl_d.closing = 1'b0;
                    trk_clear     = 1'b1;
                    tmr_load      = 1'b1;
                end else begin
                    ctl_d.st = ST_ROW;
                end
            end
            ST_PRE: begin
                if (tmr_done) begin
                    ctl_d.st = ctl_q.closing ? ST_IDLE : ST_ROW;
                end
            end
            ST_ROW: begin
                trk_capture = 1'b1;
                ctl_d.st    = ST_COL;
            end
            ST_COL: begin
                if (page_on) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.st      = ST_PRE;
                    ctl_d.closing = 1'b1;
                    trk_clear     = 1'b1;
                    tmr_load      = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, row: '0, instr: 1'b0, closing: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        dram_ras     = (ctl_q.st == ST_ROW) || (ctl_q.st == ST_COL) ||
                       (((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_CHECK)) && trk_valid);
        dram_cas     = (ctl_q.st == ST_COL);
        dram_col_sel = (ctl_q.st == ST_COL);
        req_ready    = (ctl_q.st == ST_COL);
    end

endmodule

// File: rtl/pghit_ctrl_chk.sv
module pghit_ctrl_chk #(
    parameter int PRE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras,
    input logic cas,
    input logic col_sel,
    input logic ready
);

    logic ras_prev;
    int   low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_prev <= 1'b0;
            low_cnt  <= PRE_CYC;
        end else begin
            ras_prev <= ras;
            if (ras) begin
                low_cnt <= 0;
            end else if (low_cnt < PRE_CYC) begin
                low_cnt <= low_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!ras && !cas && !ready);
        end
    end

    assert_row_before_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> $past(ras));

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_ready_with_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cas && col_sel));

    assert_precharge_met_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && !ras_prev) |-> (low_cnt >= PRE_CYC));

    assert_cas_needs_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> ras);

endmodule

bind pghit_ctrl pghit_ctrl_chk #(.PRE_CYC(PRE_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras     (dram_ras),
    .cas     (dram_cas),
    .col_sel (dram_col_sel),
    .ready   (req_ready)
);

// File: tb/pghit_ctrl_tb.sv
module pghit_ctrl_tb;

    localparam int ADDR_W  = 24;
    localparam int COL_W   = 10;
    localparam int PRE_CYC = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_is_instr;
    logic [ADDR_W-1:0] req_addr;
    logic              page_en_instr;
    logic              page_en_data;
    logic              dram_ras, dram_cas, dram_col_sel, req_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int open_row = -1;

    always #2 clk = ~clk;

    pghit_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PRE_CYC(PRE_CYC)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_is_instr  (req_is_instr),
        .req_addr      (req_addr),
        .page_en_instr (page_en_instr),
        .page_en_data  (page_en_data),
        .dram_ras      (dram_ras),
        .dram_cas      (dram_cas),
        .dram_col_sel  (dram_col_sel),
        .req_ready     (req_ready)
    );

    // vector order: {ras, cas, col_sel, ready}
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {dram_ras, dram_cas, dram_col_sel, req_ready};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got ras/cas/sel/rdy=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Entered right after a negedge with the DUT idle; returns the same way.
    task automatic run_req(input bit instr, input int row, input int col, input string tag);
        bit en;
        bit hit;
        en  = instr ? page_en_instr : page_en_data;
        hit = en && (open_row == row);
        req_valid    = 1'b1;
        req_is_instr = instr;
        req_addr     = ADDR_W'((row << COL_W) | col);
        @(negedge clk);
        chk({tag, " compare"}, {open_row >= 0, 3'b000});
        if (!hit) begin
            if (open_row >= 0) begin
                for (int i = 0; i < PRE_CYC; i++) begin
                    @(negedge clk);
                    chk({tag, " miss precharge R4 R8"}, 4'b0000);
                end
            end
            open_row = -1;
            @(negedge clk);
            chk({tag, " row phase R2"}, 4'b1000);
        end
        @(negedge clk);
        chk({tag, " column phase R7 R9"}, 4'b1111);
        req_valid = 1'b0;
        if (en) begin
            open_row = row;
        end else begin
            for (int i = 0; i < PRE_CYC; i++) begin
                @(negedge clk);
                chk({tag, " closing precharge R6 R8"}, 4'b0000);
            end
            open_row = -1;
        end
        @(negedge clk);
        chk({tag, " idle after R7"}, {open_row >= 0, 3'b000});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        req_valid     = 1'b0;
        req_is_instr  = 1'b0;
        req_addr      = '0;
        page_en_instr = 1'b0;
        page_en_data  = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 during reset", 4'b0000);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 4'b0000);

        // R2/R6: both enables clear, row closed after each access
        run_req(1'b0, 5, 3, "R2 data empty");
        run_req(1'b1, 5, 4, "R6 instr disabled");

        // R3/R4: data open page
        page_en_data = 1'b1;
        run_req(1'b0, 5, 1, "R2 data opens");
        run_req(1'b0, 5, 9, "R3 data hit");
        run_req(1'b0, 5, 0, "R3 data hit again");
        run_req(1'b0, 9, 2, "R4 data miss");

        // R5: instruction request to data-opened row, instruction enable clear
        run_req(1'b1, 9, 7, "R5 instr disabled same row");
        run_req(1'b0, 9, 7, "R2 data reopen");
        page_en_instr = 1'b1;
        run_req(1'b1, 9, 8, "R5 instr hit on data row");
        page_en_data = 1'b0;
        run_req(1'b0, 9, 1, "R5 data disabled same row");
        run_req(1'b1, 3, 2, "R2 instr opens");
        run_req(1'b1, 3, 5, "R3 instr hit");
        run_req(1'b1, 4, 5, "R4 instr miss");

        // mixed pseudo-random traffic over a small row set
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom % 16;
            if (r < 3) page_en_instr = ~page_en_instr;
            if (r > 12) page_en_data = ~page_en_data;
            run_req(($urandom % 2) == 1, 16 + ($urandom % 4), $urandom % 1024, "R5 mixed");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule